// File: doc/BRIEF.md
# Per-Area DMA Wait-State Sequencer

This block sets the length of each single-mode DMA memory read or write bus cycle. A cycle-start strobe brings in the target area number (0 to 7), the class of memory mapped there, the direction, and a 2-bit long-wait setting. The block then counts out the bus states. It raises a strobe in every state and pulses a done flag in the final one. Address and data driving, DRAM row phases, refresh and channel arbitration are handled by neighbouring logic.

Two 8-bit control fields hold one WAIT-sampling bit per area. One field applies to reads and the other to writes. These bits, together with the area number and the memory class, pick the number of base states and decide whether the active-low WAIT pin can stretch the cycle. Both fields are written through a 16-bit port with byte enables. The block takes a copy of the selected timing when a cycle starts, so a field write during a cycle does not change that cycle.

Top module: `dma_wait_seq`

## Requirements
- R1: Reset sets all 16 control bits to 1 and forces `busy` and `cyc_done` low.
- R2: A normal-class area (1, 3, 4, 5 or 7) whose control bit is 0 gives exactly 1 state, and `wait_n` has no effect on it.
- R3: A normal-class area 1, 3, 4, 5 or 7 whose control bit is 1 gives 2 base states plus any WAIT-inserted states.
- R4: A normal-class access to area 0, 2 or 6 lasts 1 state plus (`long_wait`+1) long-wait states. WAIT-inserted states are added only when the area's bit is 1.
- R5: DRAM class (`cyc_kind`=1, any area) gives 1 state with WAIT ignored when the bit is 0. When the bit is 1 it gives 2 states plus WAIT-inserted states.
- R6: Multiplexed I/O class (`cyc_kind`=2, any area) gives 4 states plus WAIT-inserted states, and WAIT is always sampled. `cyc_kind`=3 behaves as normal class.
- R7: Reads use bits 15:8 of the control word and writes use bits 7:0. Bit 8+n or bit n governs area n.
- R8: For a sampling cycle, WAIT is examined in the last base state and in every state after it. Each state with `wait_n` low adds one state, and the cycle ends in the first such state with `wait_n` high.
- R9: `cyc_start` is ignored while `busy` is high, including during the final state.
- R10: `state_stb` is high in every state of a cycle. `cyc_done` is high for exactly one clock, in the final state, and `busy` falls right after it.
- R11: When `cfg_we` is high, `cfg_be[1]` loads bits 15:8 and `cfg_be[0]` loads bits 7:0. A byte whose enable is 0 keeps its value.
- R12: A control-word write made during a cycle does not change that cycle's length. It applies from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Begin a cycle at this edge when idle |
| cyc_area | input | 3 | Target area number |
| cyc_is_read | input | 1 | 1 = read cycle, 0 = write cycle |
| cyc_kind | input | 2 | 0 normal, 1 DRAM, 2 multiplexed I/O, 3 normal |
| long_wait | input | 2 | Long-wait states minus one |
| wait_n | input | 1 | Active-low WAIT pin |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_be | input | 2 | Byte enables (1: read field, 0: write field) |
| cfg_wdata | input | 16 | Control-word write data |
| busy | output | 1 | A cycle is in progress |
| state_stb | output | 1 | High once per bus state |
| cyc_done | output | 1 | High in the final state |

## Verification
A start accepted at edge k puts state 0 in the clock after k. `busy` and `state_stb` are therefore due one edge after the strobe. `cyc_done` depends on `wait_n` through logic only, so it is valid within the same state. The bench drives `cyc_start`, `wait_n` and the write port on falling edges and samples 1 ns later. It counts one state per sampled high `busy`, requires exactly one done in the last counted state, and expects `busy` low at the next sample. Holding `wait_n` low for the first K states gives an expected length of max(base, K+1) for sampling cycles and the base length otherwise. The bench sweeps every area, class, direction, long-wait value and three control patterns against that rule.

// File: rtl/dws_pkg.sv
package dws_pkg;

    localparam int NUM_AREAS = 8;
    localparam int AREA_W    = $clog2(NUM_AREAS);
    localparam int LW_W      = 2;
    localparam int MUX_BASE  = 4;
    localparam int MAX_FIXED = (1 + (1 << LW_W) > MUX_BASE) ? 1 + (1 << LW_W) : MUX_BASE;
    localparam int CNT_W     = $clog2(MAX_FIXED);

    typedef enum logic [1:0] {
        KIND_NORMAL = 2'd0,
        KIND_DRAM   = 2'd1,
        KIND_MUXIO  = 2'd2,
        KIND_RSVD   = 2'd3
    } area_kind_e;

    typedef struct packed {
        logic [CNT_W-1:0] last_idx;  // index of the final base state
        logic             smp;       // WAIT is examined from the final base state on
    } timing_t;

    function automatic timing_t pick_short(input logic bit_on);
        timing_t t;
        t.last_idx = bit_on ? CNT_W'(1) : '0;
        t.smp      = bit_on;
        return t;
    endfunction

endpackage

// File: rtl/dws_cfg_regs.sv
module dws_cfg_regs
    import dws_pkg::*;
#(
    parameter int N = NUM_AREAS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [1:0]     be,
    input  logic [2*N-1:0] wdata,
    output logic [N-1:0]   rd_mask,
    output logic [N-1:0]   wr_mask
);

    logic [N-1:0] bank_q [2];   // [1] read field, [0] write field

    for (genvar g = 0; g < 2; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[g] <= '1;
            else if (we && be[g])
                bank_q[g] <= wdata[g*N +: N];
        end
    end

    assign rd_mask = bank_q[1];
    assign wr_mask = bank_q[0];

endmodule

// File: rtl/dws_timing_decode.sv
module dws_timing_decode
    import dws_pkg::*;
#(
    parameter int                 N         = NUM_AREAS,
    parameter logic [NUM_AREAS-1:0] LONG_MASK = 8'b0100_0101
) (
    input  logic [$clog2(N)-1:0] area,
    input  area_kind_e           kind,
    input  logic                 is_read,
    input  logic [N-1:0]         rd_mask,
    input  logic [N-1:0]         wr_mask,
    input  logic [LW_W-1:0]      long_wait,
    output timing_t              tim
);

    logic bit_on;
    logic is_long;

    assign bit_on  = is_read ? rd_mask[area] : wr_mask[area];
    assign is_long = LONG_MASK[area];

    always_comb begin
        unique case (kind)
            KIND_DRAM:  tim = pick_short(bit_on);
            KIND_MUXIO: begin
                tim.last_idx = CNT_W'(MUX_BASE - 1);
                tim.smp      = 1'b1;
            end
            default: begin
                if (is_long) begin
                    tim.last_idx = CNT_W'(long_wait) + CNT_W'(1);
                    tim.smp      = bit_on;
                end else begin
                    tim = pick_short(bit_on);
                end
            end
        endcase
    end

endmodule

// File: rtl/dws_state_ctr.sv
module dws_state_ctr
    import dws_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  timing_t tim,
    input  logic    wait_n,
    output logic    busy,
    output logic    stb,
    output logic    done
);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    timing_t          lat_q;
    logic             at_end;

    assign at_end = (cnt_q == lat_q.last_idx);
    assign done   = busy_q && at_end && (!lat_q.smp || wait_n);
    assign busy   = busy_q;
    assign stb    = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            lat_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                lat_q  <= tim;
            end
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (!at_end) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dma_wait_seq.sv
module dma_wait_seq
    import dws_pkg::*;
#(
    parameter int                   N         = NUM_AREAS,
    parameter logic [NUM_AREAS-1:0] LONG_MASK = 8'b0100_0101
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc_start,
    input  logic [2:0]    cyc_area,
    input  logic          cyc_is_read,
    input  logic [1:0]    cyc_kind,
    input  logic [1:0]    long_wait,
    input  logic          wait_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_be,
    input  logic [15:0]   cfg_wdata,
    output logic          busy,
    output logic          state_stb,
    output logic          cyc_done
);

    logic [N-1:0] rd_mask;
    logic [N-1:0] wr_mask;
    timing_t      tim;

    dws_cfg_regs #(.N(N)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .rd_mask (rd_mask),
        .wr_mask (wr_mask)
    );

    dws_timing_decode #(.N(N), .LONG_MASK(LONG_MASK)) u_dec (
        .area      (cyc_area),
        .kind      (area_kind_e'(cyc_kind)),
        .is_read   (cyc_is_read),
        .rd_mask   (rd_mask),
        .wr_mask   (wr_mask),
        .long_wait (long_wait),
        .tim       (tim)
    );

    dws_state_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .start  (cyc_start),
        .tim    (tim),
        .wait_n (wait_n),
        .busy   (busy),
        .stb    (state_stb),
        .done   (cyc_done)
    );

endmodule

// File: rtl/dws_chk.sv
module dws_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic state_stb,
    input logic cyc_done
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !cyc_done));

    // R10
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_done |-> (busy && state_stb));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_done |=> !cyc_done);

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cyc_done));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !cyc_done) |=> busy);

    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_done |=> !busy);

endmodule

bind dma_wait_seq dws_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .state_stb (state_stb),
    .cyc_done  (cyc_done)
);

// File: tb/dma_wait_seq_test.sv
`timescale 1ns/1ps
module dma_wait_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_start = 1'b0;
    logic [2:0]  cyc_area = '0;
    logic        cyc_is_read = 1'b0;
    logic [1:0]  cyc_kind = '0;
    logic [1:0]  long_wait = '0;
    logic        wait_n = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_be = '0;
    logic [15:0] cfg_wdata = '0;
    logic        busy, state_stb, cyc_done;

    int errors = 0;
    int checks = 0;
    logic [7:0] rmask_e = 8'hFF;
    logic [7:0] wmask_e = 8'hFF;

    always #2 clk = ~clk;

    dma_wait_seq uut (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_area(cyc_area),
        .cyc_is_read(cyc_is_read), .cyc_kind(cyc_kind), .long_wait(long_wait),
        .wait_n(wait_n), .cfg_we(cfg_we), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .busy(busy), .state_stb(state_stb), .cyc_done(cyc_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int area, input int kind, input bit rd,
                                   input int lw, input int k);
        bit b = rd ? rmask_e[area] : wmask_e[area];
        bit lng = (area == 0) || (area == 2) || (area == 6);
        int fixed;
        bit smp;
        if (kind == 1) begin fixed = b ? 2 : 1; smp = b; end
        else if (kind == 2) begin fixed = 4; smp = 1'b1; end
        else if (lng) begin fixed = 2 + lw; smp = b; end
        else begin fixed = b ? 2 : 1; smp = b; end
        if (smp && (k + 1 > fixed)) return k + 1;
        return fixed;
    endfunction

    function automatic string tag(input int area, input int kind, input bit rd, input int k);
        bit b = rd ? rmask_e[area] : wmask_e[area];
        string s;
        if (kind == 2) s = "R6";
        else if (kind == 1) s = "R5";
        else if (area == 0 || area == 2 || area == 6) s = "R4";
        else s = b ? "R3" : "R2";
        if (k > 0) s = {s, "/R8"};
        if (rmask_e != wmask_e) s = {s, "/R7"};
        return s;
    endfunction

    task automatic write_cfg(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = '0;
        if (be[1]) rmask_e = d[15:8];
        if (be[0]) wmask_e = d[7:0];
    endtask

    // Runs one cycle; wait_n low in states 0..k-1. Optional mid-cycle start or control write in state 0.
    task automatic run_cycle(input int area, input int kind, input bit rd, input int lw,
                             input int k, input bit poke_start, input bit poke_cfg,
                             output int len, output int ndone);
        @(negedge clk);
        cyc_area = 3'(area); cyc_kind = 2'(kind); cyc_is_read = rd;
        long_wait = 2'(lw); cyc_start = 1'b1; wait_n = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        len = 0; ndone = 0;
        for (int idx = 0; idx < 40; idx++) begin
            wait_n = (idx >= k);
            if (idx == 0 && poke_start) begin
                cyc_start = 1'b1; cyc_area = 3'd1; cyc_kind = 2'd0;
            end
            if (idx == 0 && poke_cfg) begin
                cfg_we = 1'b1; cfg_be = 2'b11; cfg_wdata = 16'h0000;
            end
            #1;
            if (!busy) break;
            len++;
            if (cyc_done) ndone++;
            @(negedge clk);
            cyc_start = 1'b0; cfg_we = 1'b0;
        end
        wait_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int len, nd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 busy after reset", int'(busy), 0);
        check("R1 done after reset", int'(cyc_done), 0);
        run_cycle(4, 0, 1'b1, 0, 2, 1'b0, 1'b0, len, nd);
        check("R1 default bit 1 (area 4 read, K=2)", len, 3);
        run_cycle(5, 0, 1'b0, 0, 2, 1'b0, 1'b0, len, nd);
        check("R1 default write bit 1 (area 5, K=2)", len, 3);

        // Sweep: three control patterns, all areas, classes, directions, long waits, WAIT spans.
        for (int p = 0; p < 3; p++) begin
            write_cfg(2'b11, (p == 0) ? 16'hFFFF : (p == 1) ? 16'h0000 : 16'h5AA5);
            for (int a = 0; a < 8; a++)
                for (int kd = 0; kd < 4; kd++)
                    for (int r = 0; r < 2; r++)
                        for (int lw = 0; lw < 4; lw++)
                            for (int ki = 0; ki < 2; ki++) begin
                                int k = ki * 6;
                                if (lw > 0 && !(kd != 1 && kd != 2 && (a == 0 || a == 2 || a == 6)))
                                    continue;
                                run_cycle(a, kd, r[0], lw, k, 1'b0, 1'b0, len, nd);
                                check(tag(a, kd, r[0], k), len, exp_len(a, kd, r[0], lw, k));
                                check("R10 one done per cycle", nd, 1);
                            end
        end

        // R11: byte enable 1 only touches read field
        write_cfg(2'b11, 16'hFFFF);
        write_cfg(2'b10, 16'h0000);
        run_cycle(1, 0, 1'b1, 0, 3, 1'b0, 1'b0, len, nd);
        check("R11 read field cleared", len, 1);
        run_cycle(1, 0, 1'b0, 0, 3, 1'b0, 1'b0, len, nd);
        check("R11 write field kept", len, 4);
        write_cfg(2'b01, 16'h00F0);
        run_cycle(1, 0, 1'b0, 0, 3, 1'b0, 1'b0, len, nd);
        check("R11 write field loaded (bit1=0)", len, 1);
        run_cycle(5, 0, 1'b0, 0, 3, 1'b0, 1'b0, len, nd);
        check("R11 write field loaded (bit5=1)", len, 4);
        run_cycle(5, 0, 1'b1, 0, 3, 1'b0, 1'b0, len, nd);
        check("R11 read field untouched by be0", len, 1);

        // R12: control write during a cycle
        write_cfg(2'b11, 16'hFFFF);
        run_cycle(3, 0, 1'b1, 0, 2, 1'b0, 1'b1, len, nd);
        rmask_e = 8'h00; wmask_e = 8'h00;
        check("R12 current cycle keeps old bit", len, 3);
        run_cycle(3, 0, 1'b1, 0, 2, 1'b0, 1'b0, len, nd);
        check("R12 next cycle uses new bit", len, 1);

        // R9: start during busy is ignored
        run_cycle(0, 2, 1'b1, 0, 0, 1'b1, 1'b0, len, nd);
        check("R9 mid-cycle start ignored (length)", len, 4);
        check("R9 mid-cycle start ignored (done count)", nd, 1);
        #1;
        check("R9 idle after cycle", int'(busy), 0);

        // R2/R5: bit 0 ignores a long WAIT low span
        run_cycle(7, 0, 1'b0, 0, 10, 1'b0, 1'b0, len, nd);
        check("R2 WAIT ignored", len, 1);
        run_cycle(2, 1, 1'b1, 0, 10, 1'b0, 1'b0, len, nd);
        check("R5 WAIT ignored short pitch", len, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule